// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Drive Sequencer

This block produces the time-multiplexed drive pattern for a passive LCD panel with up to four common lines and fifty-one segment pins. A latched display bit array and a small set of control bits select the duty (three or four commons) and the bias (halves or thirds). They also blank all segments and place the panel in a low-power state. Each cycle, every common and segment pin gets a two-bit level code that names the bias rail the analog buffer should connect to that pin.

A base-clock tick input moves the active common slot forward. After the last slot of a frame the sequence wraps to the first slot and the polarity of every level is inverted, so each pin averages to zero against its partners over two frames. One pin is shared. In four-common operation it is the fourth common. In three-common operation it becomes the fifty-first segment. Rail generation, output buffers and serial loading of the bit array sit outside this block.

Level codes: 0 = ground, 1 = lower intermediate rail (one third of supply in third bias, the half-supply rail in half bias), 2 = upper intermediate rail (two thirds of supply, used only in third bias), 3 = supply. Display bits are numbered D1..D200, and D(n) is `disp_data_i[n-1]`. Slots are numbered from 0, and slot s selects common s+1.

Top module: `lcd_mux_driver`

## Requirements
- R1: While `rst_ni` is low or `sleep_i` is 1, every output level is 0, and the sequencer is held at slot 0 with positive polarity. The first frame after wake-up starts at common 1 with positive polarity.
- R2: The slot advances by exactly one per cycle in which `tick_i` is 1. With `tick_i` at 0 and the inputs unchanged, all outputs hold.
- R3: With `duty3_i` = 0 (four-common mode), slots 0..3 select commons 1..4, and the shared pin carries common 4.
- R4: With `duty3_i` = 1 (three-common mode), slots 0..2 select commons 1..3, and the shared pin is segment 51 showing D151, D152, D153 in slots 0, 1, 2.
- R5: In positive polarity, a selected common is at 3 and an on segment is at 0. The negative polarity maps 0↔3 and 1↔2, except that in half bias code 1 stays 1. Polarity flips each time the slot wraps from the last slot to 0.
- R6: With `half_bias_i` = 0, an unselected common is at 1 and an off segment is at 2 in positive polarity. In negative polarity those become 2 and 1.
- R7: With `half_bias_i` = 1, unselected commons and off segments are at 1 in both polarities, and code 2 never appears.
- R8: In four-common mode, segment k (1..50) in slot s shows D(4(k-1)+s+1).
- R9: In three-common mode, segment k (1..50) in slot s shows D(3(k-1)+s+1).
- R10: With `seg_off_i` = 1, every segment, including the shared pin in three-common mode, takes the off level whatever the data.
- R11: If the slot lies beyond the last slot of the current mode (a switch to three-common mode while in slot 3), the next clock returns it to slot 0 without flipping polarity.
- R12: While awake, at most one common sits at an extreme level (0 or 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base-clock tick, advances the slot |
| disp_data_i | input | 200 | Display bits, D(n) at index n-1 |
| duty3_i | input | 1 | 1 = three commons, 0 = four commons |
| half_bias_i | input | 1 | 1 = half bias, 0 = third bias |
| seg_off_i | input | 1 | Force all segments off |
| sleep_i | input | 1 | Low-power state, display off |
| com_lvl_o | output | 6 | Level codes for commons 1..3, two bits each, common 1 in bits [1:0] |
| shared_lvl_o | output | 2 | Level code of the common 4 / segment 51 pin |
| seg_lvl_o | output | 100 | Level codes for segments 1..50, segment k in bits [2k-1:2k-2] |

## Verification
The bench targets the data index map in both modes, using single set bits that a wrong stride or slot offset would put on the wrong segment or slot. It also checks the shared pin in three-common mode, which a design that ignored the mode would still drive with common levels. A duty switch while in slot 3 must fall back to slot 0 on the next clock; a design without that guard would leave no common selected. The bench checks polarity inversion after the frame wrap, and checks that the half-bias middle code does not flip, since flipping it would drive the unused 2/3 rail. Sleep in mid-frame must restart the sequence at common 1 with positive polarity.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int unsigned LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LV_GND  = 2'd0,
    LV_LOW  = 2'd1,
    LV_HIGH = 2'd2,
    LV_SUP  = 2'd3
  } lvl_e;

  // negative-frame mapping; half-bias middle rail is its own mirror
  function automatic logic [LVL_W-1:0] lv_mirror(input logic [LVL_W-1:0] lv,
                                                 input logic half);
    if (half && lv == LV_LOW) return LV_LOW;
    return ~lv;
  endfunction

  function automatic logic [LVL_W-1:0] lv_apply(input logic [LVL_W-1:0] lv,
                                                input logic neg,
                                                input logic half,
                                                input logic awake);
    if (!awake) return LV_GND;
    return neg ? lv_mirror(lv, half) : lv;
  endfunction
endpackage

// File: rtl/lcd_slot_seq.sv
module lcd_slot_seq #(
  parameter int unsigned MAX_COM = 4,
  localparam int unsigned SW = $clog2(MAX_COM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          duty3_i,
  output logic [SW-1:0] slot_o,
  output logic          neg_o
);
  localparam logic [SW-1:0] LAST_FULL = SW'(MAX_COM - 1);
  localparam logic [SW-1:0] LAST_RED  = SW'(MAX_COM - 2);

  logic [SW-1:0] slot_q;
  logic          neg_q;
  logic [SW-1:0] last;

  assign last = duty3_i ? LAST_RED : LAST_FULL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      neg_q  <= 1'b0;
    end else if (!run_i) begin
      slot_q <= '0;
      neg_q  <= 1'b0;
    end else if (slot_q > last) begin
      slot_q <= '0;
    end else if (tick_i) begin
      if (slot_q == last) begin
        slot_q <= '0;
        neg_q  <= ~neg_q;
      end else begin
        slot_q <= slot_q + SW'(1);
      end
    end
  end

  assign slot_o = slot_q;
  assign neg_o  = neg_q;
endmodule

// File: rtl/lcd_com_gen.sv
module lcd_com_gen
  import lcd_drv_pkg::*;
#(
  parameter int unsigned MAX_COM = 4,
  localparam int unsigned SW = $clog2(MAX_COM)
) (
  input  logic [SW-1:0]                   slot_i,
  input  logic                            neg_i,
  input  logic                            half_i,
  input  logic                            awake_i,
  output logic [MAX_COM-1:0][LVL_W-1:0]   com_lvl_o
);
  for (genvar c = 0; c < MAX_COM; c++) begin : g_com
    logic [LVL_W-1:0] base;
    always_comb begin
      base = (slot_i == SW'(c)) ? LV_SUP : LV_LOW;
      com_lvl_o[c] = lv_apply(base, neg_i, half_i, awake_i);
    end
  end
endmodule

// File: rtl/lcd_seg_gen.sv
module lcd_seg_gen
  import lcd_drv_pkg::*;
#(
  parameter int unsigned NUM_SEG = 51,
  parameter int unsigned MAX_COM = 4,
  parameter int unsigned DATA_W  = 200,
  localparam int unsigned SW = $clog2(MAX_COM),
  localparam int unsigned IW = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]               data_i,
  input  logic [SW-1:0]                   slot_i,
  input  logic                            neg_i,
  input  logic                            half_i,
  input  logic                            duty3_i,
  input  logic                            blank_i,
  input  logic                            awake_i,
  output logic [NUM_SEG-1:0][LVL_W-1:0]   seg_lvl_o
);
  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    localparam int unsigned BASE_RED  = (MAX_COM - 1) * k;
    localparam int unsigned BASE_FULL = MAX_COM * k;
    int unsigned      idx;
    logic             on;
    logic [LVL_W-1:0] base;
    always_comb begin
      idx  = (duty3_i ? BASE_RED : BASE_FULL) + int'(slot_i);
      on   = (idx < DATA_W) ? data_i[IW'(idx)] : 1'b0;
      on   = on & ~blank_i;
      base = on ? LV_GND : (half_i ? LV_LOW : LV_HIGH);
      seg_lvl_o[k] = lv_apply(base, neg_i, half_i, awake_i);
    end
  end
endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
  import lcd_drv_pkg::*;
#(
  parameter int unsigned NUM_SEG = 51,
  parameter int unsigned MAX_COM = 4,
  parameter int unsigned DATA_W  = 200,
  localparam int unsigned SW    = $clog2(MAX_COM),
  localparam int unsigned N_COM = MAX_COM - 1,
  localparam int unsigned N_SEG = NUM_SEG - 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic [DATA_W-1:0]        disp_data_i,
  input  logic                     duty3_i,
  input  logic                     half_bias_i,
  input  logic                     seg_off_i,
  input  logic                     sleep_i,
  output logic [LVL_W*N_COM-1:0]   com_lvl_o,
  output logic [LVL_W-1:0]         shared_lvl_o,
  output logic [LVL_W*N_SEG-1:0]   seg_lvl_o
);
  logic                          awake;
  logic [SW-1:0]                 slot;
  logic                          neg;
  logic [MAX_COM-1:0][LVL_W-1:0] com_all;
  logic [NUM_SEG-1:0][LVL_W-1:0] seg_all;

  assign awake = rst_ni & ~sleep_i;

  lcd_slot_seq #(.MAX_COM(MAX_COM)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (~sleep_i),
    .tick_i (tick_i),
    .duty3_i(duty3_i),
    .slot_o (slot),
    .neg_o  (neg)
  );

  lcd_com_gen #(.MAX_COM(MAX_COM)) u_com (
    .slot_i   (slot),
    .neg_i    (neg),
    .half_i   (half_bias_i),
    .awake_i  (awake),
    .com_lvl_o(com_all)
  );

  lcd_seg_gen #(.NUM_SEG(NUM_SEG), .MAX_COM(MAX_COM), .DATA_W(DATA_W)) u_seg (
    .data_i   (disp_data_i),
    .slot_i   (slot),
    .neg_i    (neg),
    .half_i   (half_bias_i),
    .duty3_i  (duty3_i),
    .blank_i  (seg_off_i),
    .awake_i  (awake),
    .seg_lvl_o(seg_all)
  );

  for (genvar c = 0; c < N_COM; c++) begin : g_com_out
    assign com_lvl_o[LVL_W*c +: LVL_W] = com_all[c];
  end
  for (genvar k = 0; k < N_SEG; k++) begin : g_seg_out
    assign seg_lvl_o[LVL_W*k +: LVL_W] = seg_all[k];
  end

  // last common and last segment share one pin
  assign shared_lvl_o = duty3_i ? seg_all[NUM_SEG-1] : com_all[MAX_COM-1];
endmodule

// File: rtl/lcd_mux_driver_chk.sv
module lcd_mux_driver_chk #(
  parameter int unsigned NUM_SEG = 51,
  parameter int unsigned MAX_COM = 4,
  localparam int unsigned N_COM = MAX_COM - 1,
  localparam int unsigned N_SEG = NUM_SEG - 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   duty3_i,
  input logic                   half_bias_i,
  input logic                   seg_off_i,
  input logic                   sleep_i,
  input logic [2*N_COM-1:0]     com_lvl_o,
  input logic [1:0]             shared_lvl_o,
  input logic [2*N_SEG-1:0]     seg_lvl_o
);
  logic [N_COM-1:0] com_ext;
  logic [N_SEG-1:0] seg_mid;
  logic [N_SEG-1:0] seg_upper;
  logic             sh_ext;
  logic             sh_mid;

  for (genvar c = 0; c < N_COM; c++) begin : g_c
    assign com_ext[c] = (com_lvl_o[2*c +: 2] == 2'd0) || (com_lvl_o[2*c +: 2] == 2'd3);
  end
  for (genvar k = 0; k < N_SEG; k++) begin : g_s
    assign seg_mid[k]   = (seg_lvl_o[2*k +: 2] == 2'd1) || (seg_lvl_o[2*k +: 2] == 2'd2);
    assign seg_upper[k] = (seg_lvl_o[2*k +: 2] == 2'd2);
  end
  assign sh_ext = (shared_lvl_o == 2'd0) || (shared_lvl_o == 2'd3);
  assign sh_mid = (shared_lvl_o == 2'd1) || (shared_lvl_o == 2'd2);

  // R1
  display_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (com_lvl_o == '0 && shared_lvl_o == 2'd0 && seg_lvl_o == '0));

  // R12
  one_common_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |-> $onehot0({sh_ext & ~duty3_i, com_ext}));

  // R4
  three_com_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty3_i && $past(duty3_i) && !sleep_i) |-> $countones(com_ext) == 1);

  // R10
  blank_seg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_off_i && !sleep_i) |-> (&seg_mid && (!duty3_i || sh_mid)));

  // R7
  half_no_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_bias_i |-> (seg_upper == '0 && shared_lvl_o != 2'd2));
endmodule

bind lcd_mux_driver lcd_mux_driver_chk #(.NUM_SEG(NUM_SEG), .MAX_COM(MAX_COM)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .duty3_i     (duty3_i),
  .half_bias_i (half_bias_i),
  .seg_off_i   (seg_off_i),
  .sleep_i     (sleep_i),
  .com_lvl_o   (com_lvl_o),
  .shared_lvl_o(shared_lvl_o),
  .seg_lvl_o   (seg_lvl_o)
);

// File: tb/sim_lcd_mux_driver.sv
module sim_lcd_mux_driver;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0;
  logic [199:0] disp_data_i = '0;
  logic         duty3_i = 1'b0;
  logic         half_bias_i = 1'b0;
  logic         seg_off_i = 1'b0;
  logic         sleep_i = 1'b0;
  logic [5:0]   com_lvl_o;
  logic [1:0]   shared_lvl_o;
  logic [99:0]  seg_lvl_o;

  int checks = 0;
  int fails = 0;
  int m_slot = 0;
  bit m_neg = 1'b0;

  always #5 clk_i = ~clk_i;

  lcd_mux_driver u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .disp_data_i(disp_data_i),
    .duty3_i(duty3_i), .half_bias_i(half_bias_i), .seg_off_i(seg_off_i),
    .sleep_i(sleep_i), .com_lvl_o(com_lvl_o), .shared_lvl_o(shared_lvl_o),
    .seg_lvl_o(seg_lvl_o)
  );

  // {duty3, half, blank, pattern[1:0], ticks[3:0]}
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 4'd9},
    {1'b1, 1'b0, 1'b0, 2'd1, 4'd7},
    {1'b0, 1'b1, 1'b0, 2'd2, 4'd9},
    {1'b1, 1'b1, 1'b0, 2'd3, 4'd7},
    {1'b0, 1'b0, 1'b1, 2'd3, 4'd5},
    {1'b1, 1'b1, 1'b1, 2'd0, 4'd4},
    {1'b1, 1'b0, 1'b0, 2'd2, 4'd7},
    {1'b0, 1'b1, 1'b0, 2'd1, 4'd9}
  };

  function automatic bit pat_bit(int i, int p);
    case (p)
      0: return ((i * 7 + 3) % 5) < 2;
      1: return (i % 3) == 0;
      2: return ((i / 4) % 2) != (i % 2);
      default: return (i % 11) != 0;
    endcase
  endfunction

  function automatic logic [1:0] e_mirror(logic [1:0] lv, bit half);
    if (half && lv == 2'd1) return 2'd1;
    return 2'd3 - lv;
  endfunction

  function automatic logic [1:0] e_pin(logic [1:0] base, bit neg, bit half, bit awake);
    if (!awake) return 2'd0;
    return neg ? e_mirror(base, half) : base;
  endfunction

  function automatic logic [1:0] e_com(int c);
    logic [1:0] base;
    base = (c == m_slot) ? 2'd3 : 2'd1;
    return e_pin(base, m_neg, half_bias_i, rst_ni && !sleep_i);
  endfunction

  function automatic logic [1:0] e_seg(int k);
    int idx;
    bit on;
    logic [1:0] base;
    idx = (duty3_i ? 3 * k : 4 * k) + m_slot;
    on = (idx < 200) ? disp_data_i[idx] : 1'b0;
    on = on && !seg_off_i;
    base = on ? 2'd0 : (half_bias_i ? 2'd1 : 2'd2);
    return e_pin(base, m_neg, half_bias_i, rst_ni && !sleep_i);
  endfunction

  task automatic check_all(string req);
    logic [5:0]  ec;
    logic [1:0]  es;
    logic [99:0] eg;
    for (int c = 0; c < 3; c++) ec[2*c +: 2] = e_com(c);
    for (int k = 0; k < 50; k++) eg[2*k +: 2] = e_seg(k);
    es = duty3_i ? e_seg(50) : e_com(3);
    checks++;
    if (com_lvl_o !== ec || shared_lvl_o !== es || seg_lvl_o !== eg) begin
      fails++;
      $display("FAIL %s: com=%h sh=%h seg=%h expected com=%h sh=%h seg=%h",
               req, com_lvl_o, shared_lvl_o, seg_lvl_o, ec, es, eg);
    end
  endtask

  task automatic check_lvl(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse one tick, then sample at the following negedge
  task automatic do_tick();
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    if (m_slot == (duty3_i ? 2 : 3)) begin
      m_slot = 0;
      m_neg = ~m_neg;
    end else m_slot++;
    #1;
  endtask

  task automatic restart();
    sleep_i = 1'b1;
    @(negedge clk_i);
    sleep_i = 1'b0;
    m_slot = 0;
    m_neg = 1'b0;
    #1;
  endtask

  initial begin
    #(200_000 * 10);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk_i);
    #1 check_all("R1 reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1 check_lvl("R1 first slot com1", com_lvl_o[1:0], 2'd3);

    // table walk
    for (int v = 0; v < 8; v++) begin
      duty3_i = VEC[v][8];
      half_bias_i = VEC[v][7];
      seg_off_i = VEC[v][6];
      for (int i = 0; i < 200; i++) disp_data_i[i] = pat_bit(i, int'(VEC[v][5:4]));
      restart();
      check_all("R3 R4 R6 R7 R8 R9 R10 start");
      for (int t = 0; t < int'(VEC[v][3:0]); t++) begin
        @(negedge clk_i);
        do_tick();
        check_all("R2 R5 R6 R7 R8 R9 R10 step");
      end
    end

    // R2: hold without tick
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      #1 check_all("R2 hold");
    end

    // R8: single bit D41 -> segment 11, common 1
    duty3_i = 1'b0; half_bias_i = 1'b0; seg_off_i = 1'b0;
    disp_data_i = '0; disp_data_i[40] = 1'b1;
    restart();
    check_lvl("R8 seg11 slot0 on", seg_lvl_o[21:20], 2'd0);
    check_lvl("R8 seg10 slot0 off", seg_lvl_o[19:18], 2'd2);
    @(negedge clk_i); do_tick();
    check_lvl("R8 seg11 slot1 off", seg_lvl_o[21:20], 2'd2);

    // R3: shared pin as common 4 in slot 3, then R5 polarity flip
    @(negedge clk_i); do_tick();
    @(negedge clk_i); do_tick();
    check_lvl("R3 shared com4 selected", shared_lvl_o, 2'd3);
    check_lvl("R3 com1 unselected", com_lvl_o[1:0], 2'd1);

    // R11: switch to three commons while in slot 3
    duty3_i = 1'b1;
    @(negedge clk_i);
    #1;
    m_slot = 0;
    check_lvl("R11 back to com1", com_lvl_o[1:0], 2'd3);
    check_all("R11 full");

    // R5: frame wrap flips polarity
    duty3_i = 1'b0;
    restart();
    for (int i = 0; i < 4; i++) begin @(negedge clk_i); do_tick(); end
    check_lvl("R5 com1 negative frame", com_lvl_o[1:0], 2'd0);
    check_lvl("R5 com2 negative frame", com_lvl_o[3:2], 2'd2);
    check_lvl("R5 seg11 negative on", seg_lvl_o[21:20], 2'd3);

    // R9: D33 -> segment 11, common 3 in three-common mode
    duty3_i = 1'b1;
    disp_data_i = '0; disp_data_i[32] = 1'b1;
    restart();
    check_lvl("R9 seg11 slot0 off", seg_lvl_o[21:20], 2'd2);
    @(negedge clk_i); do_tick();
    @(negedge clk_i); do_tick();
    check_lvl("R9 seg11 slot2 on", seg_lvl_o[21:20], 2'd0);

    // R4: D152 on shared pin in slot 1
    disp_data_i = '0; disp_data_i[151] = 1'b1;
    restart();
    check_lvl("R4 shared slot0 off", shared_lvl_o, 2'd2);
    @(negedge clk_i); do_tick();
    check_lvl("R4 shared slot1 on", shared_lvl_o, 2'd0);

    // R10: blank the shared segment
    seg_off_i = 1'b1;
    #1 check_lvl("R10 shared blanked", shared_lvl_o, 2'd2);
    seg_off_i = 1'b0;

    // R7: half bias keeps middle code in negative frame
    half_bias_i = 1'b1;
    @(negedge clk_i); do_tick();
    @(negedge clk_i); do_tick();
    check_lvl("R7 com2 half neg", com_lvl_o[3:2], 2'd1);
    check_all("R7 full");

    // R1: sleep mid-frame, then restart at common 1
    @(negedge clk_i); do_tick();
    sleep_i = 1'b1;
    #1 check_all("R1 sleep off");
    @(negedge clk_i);
    sleep_i = 1'b0;
    m_slot = 0; m_neg = 1'b0;
    #1 check_lvl("R1 wake com1", com_lvl_o[1:0], 2'd3);
    check_all("R1 wake");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule